// File: doc/BRIEF.md
# Nine-Bit Address Mode Framer

This block sits between a UART's character shifters and the rest of the serial port. It adds multidrop addressing that uses a ninth character bit as a marker. A character whose ninth bit is one is an address character. A character whose ninth bit is zero is a data character. On the transmit side the framer can place a programmed destination address on the line as an address character, ahead of any queued data. After that it sends data characters with the ninth bit cleared. It can also pass characters whose ninth bit software has chosen.

On the receive side the framer raises a sticky status flag whenever an address character arrives. When filtering is enabled, it drops data characters that are not meant for this node. A node becomes selected when an address character equal to its receive address arrives. It stays selected until an address character that does not match arrives. When nine-bit operation is off, characters pass through as plain eight-bit characters and the address logic has no effect.

Software programs three registers through a single write port. The select code picks the register: 0 is the control register, 1 the receive address, 2 the transmit address. Control register bits:
- bit 0 enables nine-bit characters.
- bit 1 enables receive address filtering.
- bit 2 requests that the transmit address be sent.
- bit 3 selects manual ninth-bit mode.

Top module: `nbf_framer`

## Requirements
- R1: After reset, the control register reads 0, the address flag is 0 and `rx_out_valid` is 0.
- R2: With control bit 0 clear, `tx_chr` equals `{1'b0, tx_in_chr[7:0]}` and follows `tx_in_valid` and `tx_chr_ready` directly. In this mode a pending send request (bit 2) has no effect and remains set.
- R3: With bit 0 set, bit 3 clear and bit 2 set, the framer presents `{1'b1, transmit address}` with `tx_chr_valid` high. It holds `tx_in_ready` low so that upstream data waits.
- R4: Bit 2 clears itself on the clock edge where the shifter accepts the address character (`tx_chr_ready` high). While `tx_chr_ready` is low, bit 2 stays set.
- R5: With bit 0 set, bit 3 clear and no pending request, data characters go out as `{1'b0, tx_in_chr[7:0]}`.
- R6: With bits 0 and 3 set, the full nine-bit `tx_in_chr` goes out unchanged, and a send request has no effect.
- R7: With bit 0 clear, a received character appears on `rx_out_chr` one cycle later with bit 8 forced to 0. It never sets the address flag.
- R8: With bit 0 set and bit 1 clear, every received character is delivered one cycle later with all nine bits unchanged.
- R9: In nine-bit mode a received character with bit 8 set raises `lsr_addr_rcvd` one cycle later. The flag stays high until `lsr_clr` is pulsed. If a new address character arrives in the same cycle as `lsr_clr`, setting the flag wins over clearing it.
- R10: With bits 0 and 1 set:
  - address characters are never delivered;
  - data characters are delivered only after the most recent address character equalled the receive address.
- R11: Clearing bit 1 forgets any earlier match, so after filtering is re-enabled data is dropped until a new matching address arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 receive address, 2 transmit address |
| cfg_wdata | input | 8 | Write data (control uses bits 3:0) |
| ext_ctrl_o | output | 4 | Current control register value |
| tx_in_valid | input | 1 | Upstream character valid |
| tx_in_chr | input | 9 | Upstream character (bit 8 used in manual mode) |
| tx_in_ready | output | 1 | Upstream character taken |
| tx_chr_valid | output | 1 | Character offered to the transmit shifter |
| tx_chr | output | 9 | Character to the transmit shifter |
| tx_chr_ready | input | 1 | Transmit shifter accepts the character |
| rx_chr_valid | input | 1 | Receive shifter has a character |
| rx_chr | input | 9 | Character from the receive shifter |
| rx_out_valid | output | 1 | Accepted character valid |
| rx_out_chr | output | 9 | Accepted character |
| lsr_clr | input | 1 | Clears the address flag (status read) |
| lsr_addr_rcvd | output | 1 | Line status bit 8: an address character was received |

## Verification
The assertions check every cycle that:
- a pending insertion blocks upstream data and shows an address character;
- the send request drops after the shifter takes the address;
- eight-bit mode never produces a ninth bit;
- filtered address characters never reach the output;
- the flag rises only after an address character.

Only the bench scenarios show:
- the selected/deselected sequence across several addresses;
- loss of the match when filtering is switched off;
- flag set-versus-clear priority;
- that a send request survives untouched in eight-bit and manual modes.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
  localparam int CTRL_W = 4;
  localparam int BIT_EN9    = 0;
  localparam int BIT_MATCH  = 1;
  localparam int BIT_SEND   = 2;
  localparam int BIT_MANUAL = 3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RXA  = 2'd1,
    SEL_TXA  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/nbf_rst_sync.sv
module nbf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/nbf_regs.sv
module nbf_regs
  import nbf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              send_done,
  output logic [CTRL_W-1:0] ctrl,
  output logic [ADDR_W-1:0] rx_addr,
  output logic [ADDR_W-1:0] tx_addr
);
  logic [CTRL_W-1:0] ctrl_d;
  logic [ADDR_W-1:0] rxa_d, txa_d;
  logic              ctrl_en, rxa_en, txa_en;

  always_comb begin
    ctrl_en = 1'b0;
    rxa_en  = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_RXA);
    txa_en  = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_TXA);
    ctrl_d  = ctrl;
    rxa_d   = cfg_wdata;
    txa_d   = cfg_wdata;
    if (cfg_we && (cfg_sel_e'(cfg_sel) == SEL_CTRL)) begin
      ctrl_en = 1'b1;
      ctrl_d  = cfg_wdata[CTRL_W-1:0];
    end else if (send_done) begin
      ctrl_en          = 1'b1;
      ctrl_d[BIT_SEND] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      rx_addr <= '0;
      tx_addr <= '0;
    end else begin
      if (ctrl_en) ctrl    <= ctrl_d;
      if (rxa_en)  rx_addr <= rxa_d;
      if (txa_en)  tx_addr <= txa_d;
    end
  end
endmodule

// File: rtl/nbf_tx_path.sv
module nbf_tx_path #(
  parameter int ADDR_W = 8,
  localparam int CHR_W = ADDR_W + 1
) (
  input  logic              en9,
  input  logic              manual,
  input  logic              send_req,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic              in_valid,
  input  logic [CHR_W-1:0]  in_chr,
  output logic              in_ready,
  output logic              out_valid,
  output logic [CHR_W-1:0]  out_chr,
  input  logic              out_ready,
  output logic              send_done
);
  logic insert;

  always_comb begin
    insert    = en9 && !manual && send_req;
    send_done = insert && out_ready;
    if (insert) begin
      out_valid = 1'b1;
      out_chr   = {1'b1, tx_addr};
      in_ready  = 1'b0;
    end else begin
      out_valid = in_valid;
      in_ready  = out_ready;
      if (en9 && manual) out_chr = in_chr;
      else               out_chr = {1'b0, in_chr[ADDR_W-1:0]};
    end
  end
endmodule

// File: rtl/nbf_rx_filter.sv
module nbf_rx_filter #(
  parameter int ADDR_W = 8,
  localparam int CHR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en9,
  input  logic              match_en,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic              in_valid,
  input  logic [CHR_W-1:0]  in_chr,
  input  logic              flag_clr,
  output logic              out_valid,
  output logic [CHR_W-1:0]  out_chr,
  output logic              addr_flag
);
  logic             is_addr, filtering, selected_q, selected_d;
  logic             accept, out_valid_d, flag_d;
  logic [CHR_W-1:0] out_chr_d;

  always_comb begin
    is_addr    = en9 && in_chr[ADDR_W];
    filtering  = en9 && match_en;
    selected_d = selected_q;
    if (!filtering)
      selected_d = 1'b0;
    else if (in_valid && is_addr)
      selected_d = (in_chr[ADDR_W-1:0] == rx_addr);

    if (filtering) accept = !is_addr && selected_q;
    else           accept = 1'b1;
    out_valid_d = in_valid && accept;
    out_chr_d   = en9 ? in_chr : {1'b0, in_chr[ADDR_W-1:0]};

    flag_d = addr_flag;
    if (flag_clr)              flag_d = 1'b0;
    if (in_valid && is_addr)   flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selected_q <= 1'b0;
      out_valid  <= 1'b0;
      out_chr    <= '0;
      addr_flag  <= 1'b0;
    end else begin
      selected_q <= selected_d;
      out_valid  <= out_valid_d;
      if (out_valid_d) out_chr <= out_chr_d;
      addr_flag  <= flag_d;
    end
  end
endmodule

// File: rtl/nbf_framer.sv
module nbf_framer
  import nbf_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int CHR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] ext_ctrl_o,
  input  logic              tx_in_valid,
  input  logic [CHR_W-1:0]  tx_in_chr,
  output logic              tx_in_ready,
  output logic              tx_chr_valid,
  output logic [CHR_W-1:0]  tx_chr,
  input  logic              tx_chr_ready,
  input  logic              rx_chr_valid,
  input  logic [CHR_W-1:0]  rx_chr,
  output logic              rx_out_valid,
  output logic [CHR_W-1:0]  rx_out_chr,
  input  logic              lsr_clr,
  output logic              lsr_addr_rcvd
);
  logic              rst_n_s, send_done;
  logic [CTRL_W-1:0] ctrl;
  logic [ADDR_W-1:0] rx_addr, tx_addr;

  nbf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  nbf_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .send_done(send_done), .ctrl(ctrl),
    .rx_addr(rx_addr), .tx_addr(tx_addr)
  );

  nbf_tx_path #(.ADDR_W(ADDR_W)) u_tx (
    .en9(ctrl[BIT_EN9]), .manual(ctrl[BIT_MANUAL]), .send_req(ctrl[BIT_SEND]),
    .tx_addr(tx_addr), .in_valid(tx_in_valid), .in_chr(tx_in_chr),
    .in_ready(tx_in_ready), .out_valid(tx_chr_valid), .out_chr(tx_chr),
    .out_ready(tx_chr_ready), .send_done(send_done)
  );

  nbf_rx_filter #(.ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst_n(rst_n_s), .en9(ctrl[BIT_EN9]), .match_en(ctrl[BIT_MATCH]),
    .rx_addr(rx_addr), .in_valid(rx_chr_valid), .in_chr(rx_chr),
    .flag_clr(lsr_clr), .out_valid(rx_out_valid), .out_chr(rx_out_chr),
    .addr_flag(lsr_addr_rcvd)
  );

  assign ext_ctrl_o = ctrl;
endmodule

// File: rtl/nbf_framer_chk.sv
module nbf_framer_chk
  import nbf_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int CHR_W = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [CTRL_W-1:0] ext_ctrl_o,
  input logic              tx_in_ready,
  input logic              tx_chr_valid,
  input logic [CHR_W-1:0]  tx_chr,
  input logic              tx_chr_ready,
  input logic              rx_chr_valid,
  input logic [CHR_W-1:0]  rx_chr,
  input logic              rx_out_valid,
  input logic [CHR_W-1:0]  rx_out_chr,
  input logic              lsr_addr_rcvd
);
  logic ins_pend, ctrl_wr;
  assign ins_pend = ext_ctrl_o[BIT_EN9] && !ext_ctrl_o[BIT_MANUAL] && ext_ctrl_o[BIT_SEND];
  assign ctrl_wr  = cfg_we && (cfg_sel == 2'd0);

  // R3
  a_r3_hold_upstream: assert property (@(posedge clk) disable iff (!rst_n)
    ins_pend |-> (!tx_in_ready && tx_chr_valid && tx_chr[ADDR_W]));

  // R4
  a_r4_send_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_pend && tx_chr_ready && !ctrl_wr) |=> !ext_ctrl_o[BIT_SEND]);

  // R2
  a_r2_no_ninth_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_ctrl_o[BIT_EN9] && tx_chr_valid) |-> !tx_chr[ADDR_W]);

  // R7
  a_r7_plain_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_chr_valid && !ext_ctrl_o[BIT_EN9]) |=> (rx_out_valid && !rx_out_chr[ADDR_W]));

  // R10
  a_r10_addr_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_chr_valid && rx_chr[ADDR_W] && ext_ctrl_o[BIT_EN9] && ext_ctrl_o[BIT_MATCH])
      |=> !rx_out_valid);

  // R9
  a_r9_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsr_addr_rcvd) |-> $past(rx_chr_valid && rx_chr[ADDR_W] && ext_ctrl_o[BIT_EN9]));
endmodule

bind nbf_framer nbf_framer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .ext_ctrl_o(ext_ctrl_o), .tx_in_ready(tx_in_ready), .tx_chr_valid(tx_chr_valid),
  .tx_chr(tx_chr), .tx_chr_ready(tx_chr_ready), .rx_chr_valid(rx_chr_valid),
  .rx_chr(rx_chr), .rx_out_valid(rx_out_valid), .rx_out_chr(rx_out_chr),
  .lsr_addr_rcvd(lsr_addr_rcvd)
);

// File: tb/sim_nbf_framer.sv
module sim_nbf_framer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [3:0] ext_ctrl_o;
  logic       tx_in_valid = 1'b0;
  logic [8:0] tx_in_chr = 9'd0;
  logic       tx_in_ready, tx_chr_valid;
  logic [8:0] tx_chr;
  logic       tx_chr_ready = 1'b0;
  logic       rx_chr_valid = 1'b0;
  logic [8:0] rx_chr = 9'd0;
  logic       rx_out_valid;
  logic [8:0] rx_out_chr;
  logic       lsr_clr = 1'b0;
  logic       lsr_addr_rcvd;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nbf_framer u0 (.*);

  // rx vectors: {ctrl[3:0], chr[8:0], exp_valid, exp_chr[8:0]}; receive address 0x5A
  localparam logic [22:0] VEC [NVEC] = '{
    {4'h0, 9'h1A5, 1'b1, 9'h0A5},  // R7 plain mode strips ninth bit
    {4'h1, 9'h033, 1'b1, 9'h033},  // R8 data passes
    {4'h1, 9'h1C3, 1'b1, 9'h1C3},  // R8 address passes
    {4'h3, 9'h044, 1'b0, 9'h000},  // R10 dropped before match
    {4'h3, 9'h15A, 1'b0, 9'h000},  // R10 matching address consumed
    {4'h3, 9'h077, 1'b1, 9'h077},  // R10 accepted after match
    {4'h3, 9'h15B, 1'b0, 9'h000},  // R10 other address
    {4'h3, 9'h088, 1'b0, 9'h000},  // R10 dropped after mismatch
    {4'h3, 9'h15A, 1'b0, 9'h000},  // R10 reselect
    {4'h3, 9'h099, 1'b1, 9'h099},  // R10 accepted again
    {4'h1, 9'h011, 1'b1, 9'h011},  // R11 filter off
    {4'h3, 9'h022, 1'b0, 9'h000}   // R11 match forgotten
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rx_send(input logic [8:0] c);
    rx_chr_valid = 1'b1; rx_chr = c;
    @(negedge clk);
    rx_chr_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ctrl", {5'd0, ext_ctrl_o}, 9'd0);
    check("R1 flag", {8'd0, lsr_addr_rcvd}, 9'd0);
    check("R1 rx valid", {8'd0, rx_out_valid}, 9'd0);

    wr(2'd1, 8'h5A);
    for (int i = 0; i < NVEC; i++) begin
      logic [22:0] v;
      v = VEC[i];
      wr(2'd0, {4'h0, v[22:19]});
      rx_chr_valid = 1'b1; rx_chr = v[18:10];
      @(negedge clk);
      rx_chr_valid = 1'b0;
      check($sformatf("R10 vec%0d valid", i), {8'd0, rx_out_valid}, {8'd0, v[9]});
      if (v[9]) check($sformatf("R8 vec%0d chr", i), rx_out_chr, v[8:0]);
    end

    // R9 flag behaviour
    lsr_clr = 1'b1; @(negedge clk); lsr_clr = 1'b0;
    check("R9 cleared", {8'd0, lsr_addr_rcvd}, 9'd0);
    wr(2'd0, 8'h00);
    rx_send(9'h1AA);
    check("R7 no flag in plain mode", {8'd0, lsr_addr_rcvd}, 9'd0);
    wr(2'd0, 8'h01);
    rx_send(9'h1AA);
    check("R9 flag set", {8'd0, lsr_addr_rcvd}, 9'd1);
    rx_send(9'h012);
    check("R9 flag sticky", {8'd0, lsr_addr_rcvd}, 9'd1);
    lsr_clr = 1'b1; @(negedge clk); lsr_clr = 1'b0;
    check("R9 flag cleared", {8'd0, lsr_addr_rcvd}, 9'd0);
    lsr_clr = 1'b1; rx_chr_valid = 1'b1; rx_chr = 9'h101;
    @(negedge clk);
    lsr_clr = 1'b0; rx_chr_valid = 1'b0;
    check("R9 set wins over clear", {8'd0, lsr_addr_rcvd}, 9'd1);

    // transmit side, transmit address 0x3C
    wr(2'd2, 8'h3C);
    tx_in_valid = 1'b1; tx_in_chr = 9'h1F0; tx_chr_ready = 1'b1;
    wr(2'd0, 8'h04);
    check("R2 plain tx char", tx_chr, 9'h0F0);
    check("R2 plain tx ready", {7'd0, tx_chr_valid, tx_in_ready}, 9'd3);
    @(negedge clk);
    check("R2 request kept", {5'd0, ext_ctrl_o}, 9'h004);

    tx_chr_ready = 1'b0;
    wr(2'd0, 8'h05);
    check("R3 address char", tx_chr, 9'h13C);
    check("R3 upstream held", {7'd0, tx_chr_valid, tx_in_ready}, 9'd2);
    @(negedge clk);
    check("R4 kept while not ready", {5'd0, ext_ctrl_o}, 9'h005);
    tx_chr_ready = 1'b1;
    @(negedge clk);
    check("R4 self cleared", {5'd0, ext_ctrl_o}, 9'h001);
    check("R5 data ninth clear", tx_chr, 9'h0F0);
    check("R5 upstream ready", {8'd0, tx_in_ready}, 9'd1);

    wr(2'd0, 8'h0D);
    check("R6 manual passes nine bits", tx_chr, 9'h1F0);
    tx_in_chr = 9'h055;
    #1;
    check("R6 manual data", tx_chr, 9'h055);
    check("R6 upstream ready", {8'd0, tx_in_ready}, 9'd1);
    @(negedge clk);
    check("R6 request untouched", {5'd0, ext_ctrl_o}, 9'h00D);
    tx_in_valid = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule